// File: doc/BRIEF.md
# Gated Period Timer with Interrupt

This block is a 16-bit peripheral timer. Software reaches it through a small word-addressed register port. The timer counts prescaled ticks of the system clock. When the count reaches the value in the period register, the count drops back to zero and a timer event is raised. A falling edge on an external gate input can raise an event too, and the same gate level can also hold back the counting.

Every event sets a sticky interrupt flag after a fixed pipeline latency. The interrupt line is driven only when three things hold at once: the flag is set, the enable bit is set and the priority level is not zero. The 3-bit priority and 2-bit subpriority fields are stored here so that an interrupt controller outside the block can read them.

Each of the four registers has three write ports. A plain write replaces the register. A bit-clear alias clears the bits written as 1. A bit-set alias sets the bits written as 1. Any bit can therefore change without a read-modify-write sequence.

Top module: `gated_period_timer`

## Requirements
- R1: After reset, the registers read as follows: control 0x0000, count 0x0000, period 0xFFFF, interrupt control 0x0000. The irq output is 0.
- R2: The address is bus_addr[3:2] = register (0 control, 1 count, 2 period, 3 interrupt control) and bus_addr[1:0] = access. Access 0 replaces the register, 1 clears the bits written as 1, 2 sets the bits written as 1, and 3 writes nothing. Reads return the register that bus_addr[3:2] selects, in the same cycle, whatever the access bits.
- R3: Only control bits 15 (run), 7 (gate enable) and 5:4 (prescale select) are stored, and all other control bits read as 0. The prescale select gives the divide ratio: 0 is 1:1, 1 is 1:8, 2 is 1:64, 3 is 1:256. When run is set at clock edge W, the count after edge W+k equals floor(k/ratio), as long as no wrap occurs.
- R4: On a tick where the count equals the period, the count goes to 0 and does not increment. It therefore runs 0..period over and over.
- R5: If the count wraps at edge n, the flag (interrupt control bit 12) reads 1 from edge n+3 onward, and not before.
- R6: When gate enable is set, the count advances only while the synchronised gate is high. A falling edge of gate_in that is driven between clock edges sets the flag on the 6th clock edge after the drive, and not on the 5th. When gate enable is clear, a falling edge of the gate raises no event and the count ignores the gate.
- R7: Only software clears the flag, through the replace access or the clear access. A hardware event and a software clear in the same cycle leave the flag set.
- R8: Interrupt control holds the subpriority in bits 1:0, the priority in bits 4:2, the enable in bit 8 and the flag in bit 12. All other bits read 0. irq = flag AND enable AND (priority ≠ 0).
- R9: While run is 0, the count keeps its value unless software writes it. Turning the timer off resets the prescaler, so after run is set again at edge W the first count increment at ratio 1:8 occurs at edge W+8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_in | input | 1 | External gate, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register select [3:2] and access kind [1:0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
Several rules are checked by assertions on every cycle. irq never rises without flag, enable and a non-zero priority. The flag follows every event after a fixed delay and stays set unless software clears it. A match wraps the count to zero. A stopped timer keeps its count and sends no ticks. Other behaviour shows up only in the bench's scenarios. These cover the exact count sequence across the sweep of prescale ratios and periods, the alias arithmetic and the register masks, the gate synchroniser latency, the same-cycle clear against an event, and the prescaler phase after a restart.

// File: rtl/gpt_pkg.sv
// Package: shared register map, field positions and the alias write rule.
// Assumes a 16-bit data path and a 4-bit word address.
package gpt_pkg;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_PERIOD = 2'd2,
        REG_INTC   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        AL_WRITE = 2'd0,
        AL_CLR   = 2'd1,
        AL_SET   = 2'd2,
        AL_NONE  = 2'd3
    } alias_e;

    localparam int CTRL_RUN_BIT  = 15;
    localparam int CTRL_GATE_BIT = 7;
    localparam int CTRL_PS_LO    = 4;
    localparam int INT_FLAG_BIT  = 12;
    localparam int INT_EN_BIT    = 8;
    localparam int INT_PRI_LO    = 2;
    localparam int INT_SUB_LO    = 0;

    localparam logic [DATA_W-1:0] CTRL_MASK = 16'h80B0;
    localparam logic [DATA_W-1:0] INTC_MASK = 16'h111F;
    localparam logic [DATA_W-1:0] PERIOD_RST = 16'hFFFF;

    // Next register value for one access kind.
    function automatic logic [DATA_W-1:0] apply_alias(
        input alias_e            al,
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] wd
    );
        case (al)
            AL_WRITE: return wd;
            AL_CLR:   return cur & ~wd;
            AL_SET:   return cur | wd;
            default:  return cur;
        endcase
    endfunction
endpackage

// File: rtl/gpt_prescaler.sv
// Prescaler: divides the clock by 1, 8, 64 or 256 and sends a single-cycle tick.
// Assumes PS_W >= 8. The phase counter is held at zero while the timer is stopped.
module gpt_prescaler #(
    parameter int PS_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [PS_W-1:0] phase_q;
    logic [PS_W-1:0] limit;

    // Last phase value for the selected ratio.
    always_comb begin
        case (sel)
            2'd0:    limit = PS_W'(0);
            2'd1:    limit = PS_W'(7);
            2'd2:    limit = PS_W'(63);
            default: limit = PS_W'(255);
        endcase
    end

    assign tick = run && (phase_q == limit);

    // Phase counter: restarts on each tick and holds at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) phase_q <= '0;
        else                        phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/gpt_gate_sync.sv
// Gate synchroniser: a chain of STAGES flops that brings the asynchronous gate
// into the clock domain, followed by falling-edge detection on the synchronised level.
module gpt_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    output logic gate_lvl,
    output logic gate_fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // First stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= gate_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Later stages move the level along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
        end
    end

    // Delayed copy of the synchronised level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign gate_lvl  = chain_q[STAGES-1];
    assign gate_fall = prev_q && !chain_q[STAGES-1];
endmodule

// File: rtl/gpt_counter.sv
// Counter: on each qualified tick it increments, or goes back to zero when it
// equals the period. A software load takes priority over counting. match is
// asserted in the tick cycle where the count equals the period.
module gpt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         gate_en,
    input  logic         gate_lvl,
    input  logic [W-1:0] period,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] count,
    output logic         match
);
    logic [W-1:0] cnt_q;
    logic         adv;

    assign adv   = tick && (!gate_en || gate_lvl);
    assign match = adv && (cnt_q == period);
    assign count = cnt_q;

    // Count register: load, then wrap, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (ld)    cnt_q <= ld_val;
        else if (match) cnt_q <= '0;
        else if (adv)   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/gpt_event_pipe.sv
// Event pipe: a fixed delay of LAT flops on the event pulse, so the flag sets
// a known number of cycles after the event.
module gpt_event_pipe #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic evt_late
);
    logic [LAT-1:0] pipe_q;

    // Entry stage.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q[0] <= 1'b0;
        else        pipe_q[0] <= evt;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_dly
        // Later delay stages.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q[i] <= 1'b0;
            else        pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign evt_late = pipe_q[LAT-1];
endmodule

// File: rtl/gated_period_timer.sv
// Top: the register file with replace, clear and set access, plus the
// prescaler, gate synchroniser, counter and event pipe. Reads are combinational
// from the address. A hardware flag set takes priority over a software clear.
module gated_period_timer
    import gpt_pkg::*;
#(
    parameter int PS_W       = 8,
    parameter int SYNC_STAGE = 2,
    parameter int EVT_LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_in,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] ctrl_q, period_q, intc_q, count;
    logic [DATA_W-1:0] intc_sw;
    reg_sel_e          sel;
    alias_e            al;
    logic              acc, run, gate_en, tick, gate_lvl, gate_fall;
    logic              match, evt, evt_late, cnt_wr, sw_flag_clr;
    logic              flag, int_en;
    logic [2:0]        int_pri;

    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign al      = alias_e'(bus_addr[1:0]);
    assign acc     = bus_wr && (al != AL_NONE);
    assign run     = ctrl_q[CTRL_RUN_BIT];
    assign gate_en = ctrl_q[CTRL_GATE_BIT];
    assign cnt_wr  = acc && (sel == REG_COUNT);

    // Control register with only its defined bits stored.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (acc && sel == REG_CTRL)
            ctrl_q <= apply_alias(al, ctrl_q, bus_wdata) & CTRL_MASK;
    end

    // Period register.
    always_ff @(posedge clk) begin
        if (!rst_n) period_q <= PERIOD_RST;
        else if (acc && sel == REG_PERIOD)
            period_q <= apply_alias(al, period_q, bus_wdata);
    end

    // Software view of the next interrupt control value.
    always_comb begin
        intc_sw = intc_q;
        if (acc && sel == REG_INTC)
            intc_sw = apply_alias(al, intc_q, bus_wdata) & INTC_MASK;
    end

    assign sw_flag_clr = intc_q[INT_FLAG_BIT] && !intc_sw[INT_FLAG_BIT];

    // Interrupt control register: the delayed hardware event sets the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) intc_q <= '0;
        else begin
            intc_q <= intc_sw;
            if (evt_late) intc_q[INT_FLAG_BIT] <= 1'b1;
        end
    end

    gpt_prescaler #(.PS_W(PS_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run),
        .sel(ctrl_q[CTRL_PS_LO +: 2]), .tick(tick)
    );

    gpt_gate_sync #(.STAGES(SYNC_STAGE)) u_gate (
        .clk(clk), .rst_n(rst_n), .gate_in(gate_in),
        .gate_lvl(gate_lvl), .gate_fall(gate_fall)
    );

    gpt_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate_en(gate_en),
        .gate_lvl(gate_lvl), .period(period_q), .ld(cnt_wr),
        .ld_val(apply_alias(al, count, bus_wdata)),
        .count(count), .match(match)
    );

    assign evt = match || (gate_fall && gate_en && run);

    gpt_event_pipe #(.LAT(EVT_LAT)) u_pipe (
        .clk(clk), .rst_n(rst_n), .evt(evt), .evt_late(evt_late)
    );

    assign flag    = intc_q[INT_FLAG_BIT];
    assign int_en  = intc_q[INT_EN_BIT];
    assign int_pri = intc_q[INT_PRI_LO +: 3];
    assign irq     = flag && int_en && (int_pri != 3'd0);

    // Read multiplexer.
    always_comb begin
        case (sel)
            REG_CTRL:   bus_rdata = ctrl_q;
            REG_COUNT:  bus_rdata = count;
            REG_PERIOD: bus_rdata = period_q;
            default:    bus_rdata = intc_q;
        endcase
    end
endmodule

// File: rtl/gated_period_timer_chk.sv
// Checker: properties that must hold on every cycle, bound into the timer top.
// The flag latency property assumes the default event pipe depth of 3.
module gated_period_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        flag,
    input logic        int_en,
    input logic [2:0]  int_pri,
    input logic        evt,
    input logic        match,
    input logic        tick,
    input logic        run,
    input logic        cnt_wr,
    input logic        sw_flag_clr,
    input logic [15:0] count
);
    AST_IRQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && int_en && int_pri != 3'd0));                 // R8
    AST_PRIO_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (int_pri == 3'd0) |-> !irq);                                   // R8
    AST_FLAG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt, 4) |-> flag);                                       // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag) && !$past(sw_flag_clr)) |-> flag);                // R7
    AST_MATCH_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(match) && !$past(cnt_wr)) |-> (count == 16'd0));        // R4
    AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!run) && !$past(cnt_wr)) |-> $stable(count));           // R9
    AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);                                               // R9
endmodule

bind gated_period_timer gated_period_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .flag(flag), .int_en(int_en),
    .int_pri(int_pri), .evt(evt), .match(match), .tick(tick), .run(run),
    .cnt_wr(cnt_wr), .sw_flag_clr(sw_flag_clr), .count(count)
);

// File: tb/gated_period_timer_bench.sv
// Bench: a sweep over prescale ratios and periods, alias arithmetic, gate
// timing, interrupt masking and stop/restart. Inputs are driven after a
// clock edge and outputs are sampled 1 ns after the edge.
module gated_period_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate_in = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    localparam logic [3:0] A_CTRL = 4'h0, A_COUNT = 4'h4, A_PER = 4'h8,
                           A_PER_CLR = 4'h9, A_PER_SET = 4'hA, A_PER_NONE = 4'hB,
                           A_INTC = 4'hC, A_INTC_CLR = 4'hD;

    gated_period_timer u_gated_period_timer (
        .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic report;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c0;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset values
        rd(A_CTRL, v);   check("R1 ctrl", v, 16'h0000);
        rd(A_COUNT, v);  check("R1 count", v, 16'h0000);
        rd(A_PER, v);    check("R1 period", v, 16'hFFFF);
        rd(A_INTC, v);   check("R1 intc", v, 16'h0000);
        check("R1 irq", irq, 0);

        // R2 access kinds on the period register
        wr(A_PER_CLR, 16'h00F0); rd(A_PER, v); check("R2 clr", v, 16'hFF0F);
        wr(A_PER_SET, 16'h0030); rd(A_PER, v); check("R2 set", v, 16'hFF3F);
        wr(A_PER, 16'h1234);     rd(A_PER, v); check("R2 write", v, 16'h1234);
        wr(A_PER_NONE, 16'h0000); rd(A_PER, v); check("R2 none", v, 16'h1234);
        rd(A_PER_CLR, v);        check("R2 read alias", v, 16'h1234);
        // R3 and R8 register masks
        wr(A_CTRL, 16'hFFFF); rd(A_CTRL, v); check("R3 mask", v, 16'h80B0);
        wr(A_CTRL, 16'h0000); rd(A_CTRL, v); check("R3 off", v, 16'h0000);
        wr(A_INTC, 16'hEEE0); rd(A_INTC, v); check("R8 mask", v, 16'h0000);

        // R3 R4 R5 sweep of prescale ratio and period
        for (int ps = 0; ps < 2; ps++) begin
            for (int p = 0; p < 5; p++) begin
                int r, kw;
                r = (ps == 0) ? 1 : 8;
                kw = r * (p + 1);
                wr(A_CTRL, 16'h0000);
                step(5);
                wr(A_COUNT, 16'h0000);
                wr(A_PER, 16'(p));
                wr(A_INTC_CLR, 16'h1000);
                wr(A_CTRL, 16'h8000 | 16'(ps << 4));
                for (int k = 1; k <= kw + 5; k++) begin
                    step(1);
                    rd(A_COUNT, v);
                    check("R3/R4 count", v, (k / r) % (p + 1));
                    rd(A_INTC, v);
                    check("R5 flag", v[12], (k >= kw + 3) ? 1 : 0);
                end
            end
        end

        // R6 gated counting and gate falling edge
        wr(A_CTRL, 16'h0000); step(5);
        wr(A_COUNT, 16'h0000); wr(A_PER, 16'hFFFF); wr(A_INTC_CLR, 16'h1000);
        wr(A_CTRL, 16'h8080);
        step(4);
        rd(A_COUNT, v); check("R6 gate high count", v, 4);
        gate_in = 1'b0;
        step(5);
        rd(A_COUNT, v); check("R6 gate low holds", v, 6);
        rd(A_INTC, v);  check("R6 flag not yet", v[12], 0);
        step(1);
        rd(A_INTC, v);  check("R6 flag on 6th", v[12], 1);
        step(3);
        rd(A_COUNT, v); check("R6 still held", v, 6);
        // R6 gate disabled: no event and free counting
        wr(A_CTRL, 16'h0000); gate_in = 1'b1; step(6);
        wr(A_COUNT, 16'h0000); wr(A_INTC_CLR, 16'h1000);
        wr(A_CTRL, 16'h8000);
        step(3);
        gate_in = 1'b0;
        step(8);
        rd(A_INTC, v);  check("R6 no gate event", v[12], 0);
        rd(A_COUNT, v); check("R6 ignores gate", v, 11);
        gate_in = 1'b1;

        // R8 irq over enable and priority
        wr(A_CTRL, 16'h0000); step(5);
        for (int en = 0; en < 2; en++) begin
            for (int pr = 0; pr < 8; pr++) begin
                wr(A_INTC, 16'h1000 | 16'(en << 8) | 16'(pr << 2) | 16'(pr & 3));
                check("R8 irq", irq, (en == 1 && pr != 0) ? 1 : 0);
            end
        end
        wr(A_INTC, 16'h011C);
        check("R8 no flag no irq", irq, 0);

        // R7 event wins over clear, then software clear works
        wr(A_INTC, 16'h0000);
        wr(A_COUNT, 16'h0000); wr(A_PER, 16'h0000);
        wr(A_CTRL, 16'h8000);
        step(5);
        wr(A_INTC_CLR, 16'h1000);
        rd(A_INTC, v); check("R7 event wins", v[12], 1);
        wr(A_CTRL, 16'h0000);
        step(5);
        rd(A_INTC, v); check("R7 sticky", v[12], 1);
        wr(A_INTC_CLR, 16'h1000);
        rd(A_INTC, v); check("R7 cleared", v[12], 0);
        step(4);
        rd(A_INTC, v); check("R7 stays clear", v[12], 0);

        // R9 stopped count frozen and prescaler restart
        wr(A_PER, 16'hFFFF); wr(A_COUNT, 16'h0000);
        wr(A_CTRL, 16'h8000); step(4);
        wr(A_CTRL, 16'h0000);
        rd(A_COUNT, c0);
        step(10);
        rd(A_COUNT, v); check("R9 frozen", v, c0);
        wr(A_CTRL, 16'h8010); step(3);
        wr(A_CTRL, 16'h0000);
        rd(A_COUNT, c0);
        wr(A_CTRL, 16'h8010);
        step(7);
        rd(A_COUNT, v); check("R9 edge 7", v, c0);
        step(1);
        rd(A_COUNT, v); check("R9 edge 8", v, c0 + 1);

        done = 1'b1;
        report();
        $finish;
    end
endmodule